// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the event flags raised by the channels of a multi-channel DMA engine and turns them into four interrupt request lines. Every channel has a 12-bit event input and two registers of its own: an event mask and a sticky status. An event bit that passes the mask is latched in the channel status, and it also marks the channel in a one-bit-per-channel summary. Each of the four lines owns a status register and an enable register. A line status collects the summary bits that its enable lets through, and the line stays high for as long as that status holds any set bit.

Software reaches every register through a word-addressed 32-bit read/write port with a 12-bit byte offset. Read data is registered. The global space also holds a fixed identification word, a constant ready flag, a configuration word whose bit 1 resets the block, and a masked global control word. The per-channel registers sit in windows that repeat at a fixed stride.

Top module: `dmairq_agg`

## Requirements
- R1: Offset 0x000 always reads 0x00000040 and offset 0x028 always reads 0x00000001. Writes to either offset change nothing.
- R2: A read issued with `rd_en` in one cycle shows its data on `rdata` after the next rising edge. Offsets that map to no register read as zero. Inside a channel window this covers every offset other than +0x08 and +0x0C, and it covers windows of channels at or above NUM_CH.
- R3: Channel c has its window at 0x080 + 0x060*c. Its event mask sits at window offset +0x08, resets to 0x003, and on a write keeps only the written bits under mask 0x9BE.
- R4: Event bit i of channel c (input bits `ch_evt[12*c+i]`) sets bit i of that channel's sticky status at window offset +0x0C only when mask bit i is 1. The status holds until software writes a one to that bit.
- R5: A channel with at least one accepted event sets summary bit c. Line l (0..3) ORs summary AND its enable into its status at offset 0x008+4*l. The enable is at 0x018+4*l, and its bit c stands for channel c. Both registers are NUM_CH bits wide.
- R6: `irq_o[l]` is high exactly when line l status is nonzero. An event driven in one cycle raises the line after the next rising edge.
- R7: Writing a line status clears the bits written as one. The line falls once its status is zero. Clearing a channel status leaves the line statuses unchanged.
- R8: When a write-one-to-clear and a hardware set hit the same bit of a channel status or a line status in the same cycle, the bit stays set.
- R9: Offset 0x02C stores the written value AND 0x3321. A write there with bit 1 set returns every other register to its reset value at the same edge and drops all lines.
- R10: Offset 0x078 stores the written value AND 0x00FF00FF.
- R11: After reset all line statuses, line enables, channel statuses, configuration and global control read zero, every channel mask reads 0x003 and all lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch_evt | input | 12*NUM_CH | Per-channel event flags, 12 bits per channel |
| irq_o | output | 4 | Interrupt request lines |

## Verification
The case that needs care is a hardware event and a software write-one-to-clear landing on the same status bit in the same clock. The bench drives the clearing write and the matching event pulse from one falling edge, so both are sampled by the same rising edge. This is done once for a line status and once for a channel status. The bit is judged by reading it back and by checking that the line is still high. A plain clear with no event follows, which shows that the write alone would have emptied the bit.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int EVT_W     = 12;
    localparam int NUM_LINES = 4;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = 5;

    localparam logic [EVT_W-1:0] CH_MASK_KEEP  = 12'h9BE;
    localparam logic [EVT_W-1:0] CH_MASK_RESET = 12'h003;

    localparam logic [31:0] ID_WORD    = 32'h0000_0040;
    localparam logic [31:0] READY_WORD = 32'h0000_0001;
    localparam logic [31:0] CFG_KEEP   = 32'h0000_3321;
    localparam logic [31:0] GCTL_KEEP  = 32'h00FF_00FF;
    localparam int          CFG_SRST_BIT = 1;

    localparam logic [ADDR_W-1:0] A_ID       = 12'h000;
    localparam logic [ADDR_W-1:0] A_LSTAT0   = 12'h008;
    localparam logic [ADDR_W-1:0] A_LEN0     = 12'h018;
    localparam logic [ADDR_W-1:0] A_READY    = 12'h028;
    localparam logic [ADDR_W-1:0] A_CFG      = 12'h02C;
    localparam logic [ADDR_W-1:0] A_GCTL     = 12'h078;
    localparam logic [ADDR_W-1:0] A_WIN0     = 12'h080;
    localparam int                WIN_STRIDE = 96;
    localparam logic [ADDR_W-1:0] W_MASK     = 12'h008;
    localparam logic [ADDR_W-1:0] W_STAT     = 12'h00C;

    typedef struct packed {
        logic                 id;
        logic                 ready;
        logic                 cfg;
        logic                 gctl;
        logic [NUM_LINES-1:0] lstat;
        logic [NUM_LINES-1:0] len;
        logic                 cmask;
        logic                 cstat;
        logic [IDX_W-1:0]     cidx;
    } regsel_t;

    function automatic logic [ADDR_W-1:0] line_addr(input logic [ADDR_W-1:0] base, input int l);
        return base + ADDR_W'(4 * l);
    endfunction

    function automatic logic [ADDR_W-1:0] win_addr(input int c, input logic [ADDR_W-1:0] off);
        return A_WIN0 + ADDR_W'(c * WIN_STRIDE) + off;
    endfunction

    function automatic logic sel_mapped(input regsel_t s);
        return s.id | s.ready | s.cfg | s.gctl | (|s.lstat) | (|s.len) | s.cmask | s.cstat;
    endfunction

endpackage

// File: rtl/dmairq_regdec.sv
module dmairq_regdec
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_t           sel
);

    always_comb begin
        sel       = '0;
        sel.id    = (addr == A_ID);
        sel.ready = (addr == A_READY);
        sel.cfg   = (addr == A_CFG);
        sel.gctl  = (addr == A_GCTL);
        for (int l = 0; l < NUM_LINES; l++) begin
            sel.lstat[l] = (addr == line_addr(A_LSTAT0, l));
            sel.len[l]   = (addr == line_addr(A_LEN0, l));
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == win_addr(c, W_MASK)) begin
                sel.cmask = 1'b1;
                sel.cidx  = IDX_W'(c);
            end
            if (addr == win_addr(c, W_STAT)) begin
                sel.cstat = 1'b1;
                sel.cidx  = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic [EVT_W-1:0] evt,
    input  logic             mask_we,
    input  logic             stat_we,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] mask_q,
    output logic [EVT_W-1:0] stat_q,
    output logic             hit
);

    logic [EVT_W-1:0] accepted;
    logic [EVT_W-1:0] wipe;

    assign accepted = evt & mask_q;
    assign hit      = |accepted;
    assign wipe     = stat_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (clr) begin
            mask_q <= CH_MASK_RESET;
            stat_q <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata & CH_MASK_KEEP;
            end
            stat_q <= (stat_q & ~wipe) | accepted;
        end
    end

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (clr)
        mask_we |=> ((mask_q & ~CH_MASK_KEEP) == '0)); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (clr)
        !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4

    AST_CH_SET_WINS: assert property (@(posedge clk) disable iff (clr)
        (stat_we && hit) |=> ((stat_q & $past(accepted)) == $past(accepted))); // R8

endmodule

// File: rtl/dmairq_line.sv
module dmairq_line
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [NUM_CH-1:0] summary,
    input  logic              en_we,
    input  logic              stat_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] stat_q,
    output logic              irq
);

    logic [NUM_CH-1:0] routed;
    logic [NUM_CH-1:0] wipe;

    assign routed = summary & en_q;
    assign wipe   = stat_we ? wdata : '0;
    assign irq    = |stat_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= wdata;
            end
            stat_q <= (stat_q & ~wipe) | routed;
        end
    end

    AST_LINE_RAISE: assert property (@(posedge clk) disable iff (clr)
        (routed != '0) |=> irq); // R6

    AST_LINE_DROP: assert property (@(posedge clk) disable iff (clr)
        (stat_we && ((wdata & stat_q) == stat_q) && (routed == '0)) |=> !irq); // R7

endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [EVT_W*NUM_CH-1:0] ch_evt,
    output logic [NUM_LINES-1:0]    irq_o
);

    regsel_t           sel;
    logic              soft_rst;
    logic              clr;
    logic [NUM_CH-1:0] summary;
    logic [EVT_W-1:0]  ch_mask [NUM_CH];
    logic [EVT_W-1:0]  ch_stat [NUM_CH];
    logic [NUM_CH-1:0] ln_en   [NUM_LINES];
    logic [NUM_CH-1:0] ln_stat [NUM_LINES];
    logic [31:0]       cfg_q;
    logic [31:0]       gctl_q;
    logic [31:0]       rd_next;
    logic [31:0]       rdata_q;

    dmairq_regdec #(.NUM_CH(NUM_CH)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign soft_rst = wr_en & sel.cfg & wdata[CFG_SRST_BIT];
    assign clr      = rst | soft_rst;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic pick;
        assign pick = (sel.cidx == IDX_W'(c));
        dmairq_chan u_chan (
            .clk     (clk),
            .clr     (clr),
            .evt     (ch_evt[c*EVT_W +: EVT_W]),
            .mask_we (wr_en & sel.cmask & pick),
            .stat_we (wr_en & sel.cstat & pick),
            .wdata   (wdata[EVT_W-1:0]),
            .mask_q  (ch_mask[c]),
            .stat_q  (ch_stat[c]),
            .hit     (summary[c])
        );
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        dmairq_line #(.NUM_CH(NUM_CH)) u_line (
            .clk     (clk),
            .clr     (clr),
            .summary (summary),
            .en_we   (wr_en & sel.len[l]),
            .stat_we (wr_en & sel.lstat[l]),
            .wdata   (wdata[NUM_CH-1:0]),
            .en_q    (ln_en[l]),
            .stat_q  (ln_stat[l]),
            .irq     (irq_o[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && sel.cfg) begin
            cfg_q <= wdata & CFG_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            gctl_q <= '0;
        end else if (wr_en && sel.gctl) begin
            gctl_q <= wdata & GCTL_KEEP;
        end
    end

    always_comb begin
        rd_next = '0;
        if (sel.id)    rd_next = ID_WORD;
        if (sel.ready) rd_next = READY_WORD;
        if (sel.cfg)   rd_next = cfg_q;
        if (sel.gctl)  rd_next = gctl_q;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (sel.lstat[l]) rd_next = 32'(ln_stat[l]);
            if (sel.len[l])   rd_next = 32'(ln_en[l]);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel.cidx == IDX_W'(c)) begin
                if (sel.cmask) rd_next = 32'(ch_mask[c]);
                if (sel.cstat) rd_next = 32'(ch_stat[c]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_next;
        end
    end

    assign rdata = rdata_q;

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel.id) |=> (rdata == ID_WORD)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel_mapped(sel)) |=> (rdata == '0)); // R2

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (irq_o == '0)); // R9

endmodule

// File: tb/test_dmairq_agg.sv
`timescale 1ns/1ps
module test_dmairq_agg;

    localparam int NCH = 8;
    localparam int EW  = 12;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en;
    logic            rd_en;
    logic [11:0]     addr;
    logic [31:0]     wdata;
    logic [31:0]     rdata;
    logic [EW*NCH-1:0] ch_evt;
    logic [3:0]      irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dmairq_agg #(.NUM_CH(NCH)) i_dmairq_agg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .ch_evt (ch_evt),
        .irq_o  (irq_o)
    );

    // {is_write, offset, write data or expected read data}
    localparam int NV = 19;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0000_0040},
        {1'b0, 12'h028, 32'h0000_0001},
        {1'b1, 12'h000, 32'h0000_FFFF},
        {1'b1, 12'h028, 32'h0000_0000},
        {1'b0, 12'h000, 32'h0000_0040},
        {1'b0, 12'h028, 32'h0000_0001},
        {1'b0, 12'h088, 32'h0000_0003},
        {1'b1, 12'h088, 32'hFFFF_FFFF},
        {1'b0, 12'h088, 32'h0000_09BE},
        {1'b1, 12'h078, 32'hFFFF_FFFF},
        {1'b0, 12'h078, 32'h00FF_00FF},
        {1'b1, 12'h02C, 32'h0000_FFFD},
        {1'b0, 12'h02C, 32'h0000_3321},
        {1'b1, 12'h018, 32'hFFFF_FFFF},
        {1'b0, 12'h018, 32'h0000_00FF},
        {1'b0, 12'h004, 32'h0000_0000},
        {1'b0, 12'h380, 32'h0000_0000},
        {1'b0, 12'h084, 32'h0000_0000},
        {1'b0, 12'h32C, 32'h0000_0000}
    };
    localparam string VTAG [NV] = '{
        "R1", "R1", "R1", "R1", "R1", "R1",
        "R3", "R3", "R3",
        "R10", "R10",
        "R9", "R9",
        "R5", "R5",
        "R2", "R2", "R2", "R4"
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input int c, input logic [11:0] e);
        ch_evt[c*EW +: EW] = e;
        @(negedge clk);
        ch_evt = '0;
    endtask

    task automatic wr_pulse(input logic [11:0] a, input logic [31:0] d, input int c, input logic [11:0] e);
        wr_en = 1'b1; addr = a; wdata = d;
        ch_evt[c*EW +: EW] = e;
        @(negedge clk);
        wr_en = 1'b0;
        ch_evt = '0;
    endtask

    task automatic summary_out;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary_out();
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ch_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        chk("R11 irq", 32'(irq_o), 32'h0);
        rd_chk("R11 line0 status", 12'h008, 32'h0);
        rd_chk("R11 line0 enable", 12'h018, 32'h0);
        rd_chk("R11 ch0 status", 12'h08C, 32'h0);
        rd_chk("R11 ch2 mask", 12'h148, 32'h3);
        rd_chk("R11 config", 12'h02C, 32'h0);
        rd_chk("R11 global ctl", 12'h078, 32'h0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
            else rd_chk(VTAG[i], VEC[i][43:32], VEC[i][31:0]);
        end

        // R9: soft reset restores the rest, config keeps masked value
        wr(12'h02C, 32'h0000_0002);
        rd_chk("R9 config", 12'h02C, 32'h0);
        rd_chk("R9 line0 enable", 12'h018, 32'h0);
        rd_chk("R9 ch0 mask", 12'h088, 32'h3);
        rd_chk("R9 global ctl", 12'h078, 32'h0);

        // routing setup
        wr(12'h018, 32'h02);
        wr(12'h020, 32'h82);
        wr(12'h01C, 32'h08);
        wr(12'h328, 32'hFFF);

        // R4/R5/R6: ch1 event, only bit 0 passes the reset mask
        pulse(1, 12'h005);
        chk("R6 irq after ch1", 32'(irq_o), 32'h5);
        rd_chk("R4 ch1 status", 12'h0EC, 32'h001);
        rd_chk("R5 line0 status", 12'h008, 32'h02);
        rd_chk("R5 line2 status", 12'h010, 32'h02);
        rd_chk("R5 line1 status", 12'h00C, 32'h0);

        // R4: masked event is ignored
        pulse(3, 12'h004);
        chk("R4 irq masked event", 32'(irq_o), 32'h5);
        rd_chk("R4 ch3 status", 12'h1AC, 32'h0);
        rd_chk("R4 line1 status", 12'h00C, 32'h0);

        // R7: channel clear leaves line, line clears drop lines
        wr(12'h0EC, 32'h001);
        rd_chk("R4 ch1 cleared", 12'h0EC, 32'h0);
        rd_chk("R7 line0 kept", 12'h008, 32'h02);
        wr(12'h008, 32'h02);
        chk("R7 irq line0 low", 32'(irq_o), 32'h4);
        rd_chk("R7 line0 cleared", 12'h008, 32'h0);
        wr(12'h010, 32'h02);
        chk("R7 irq all low", 32'(irq_o), 32'h0);

        // R6: high event bit on last channel
        pulse(7, 12'h800);
        chk("R6 irq after ch7", 32'(irq_o), 32'h4);
        rd_chk("R4 ch7 status", 12'h32C, 32'h800);
        rd_chk("R5 line2 ch7", 12'h010, 32'h80);

        // R8: set beats clear on line and channel status
        wr_pulse(12'h010, 32'h80, 7, 12'h800);
        chk("R8 irq line2 held", 32'(irq_o), 32'h4);
        rd_chk("R8 line2 status", 12'h010, 32'h80);
        wr_pulse(12'h32C, 32'h800, 7, 12'h800);
        rd_chk("R8 ch7 status", 12'h32C, 32'h800);
        wr(12'h32C, 32'h800);
        rd_chk("R4 ch7 cleared", 12'h32C, 32'h0);

        // R9: soft reset with a live line
        wr(12'h02C, 32'h0000_3323);
        chk("R9 irq dropped", 32'(irq_o), 32'h0);
        rd_chk("R9 config masked", 12'h02C, 32'h3321);
        rd_chk("R9 line2 enable", 12'h020, 32'h0);
        rd_chk("R9 ch7 mask", 12'h328, 32'h3);

        summary_out();
        $finish;
    end

endmodule